// File: doc/BRIEF.md
# Reply Rate Governor with Random Filler Pairs

This block keeps the transmitter's pulse-pair rate inside a window set by two registers. It counts every pair that goes on air over a sliding window made of sixteen sub-intervals. At the 50 MHz default each sub-interval is 62.5 ms, so the window is one second and the limits read directly as pairs per second. When real replies are too few, the block inserts filler pairs. The gap before each filler is drawn from a 16-bit maximal-length LFSR, so fillers are not periodic. When replies exceed the ceiling, the block does not drop replies. Instead it raises a threshold offset in 1 dB steps toward the receiver, which lowers sensitivity, and it drives an overload flag while that offset is nonzero.

Every transmit event, whether a reply or a filler, leaves the block as a two-pulse gate sequence. The pair spacing can be selected between a narrow and a wide value. A reply request from the decoder takes priority over a filler. A request that arrives while a pair is on air is held, one deep, and sent as soon as the gate sequencer is free.

Top module: `rrg_governor`

## Requirements
- R1: While reset is high, `tx_gate`, `tx_filler` and `overload` are low and `thr_offset` is zero.
- R2: Every gate pulse is high for exactly GATE_W clock cycles.
- R3: The rising edges of the two pulses of a pair are SPACE_N cycles apart when `cfg_wide_space` is 0 and SPACE_W cycles apart when it is 1. The choice is latched when the pair starts.
- R4: Each `reply_req` strobe yields exactly one pair with `tx_filler` low. A strobe that arrives while a pair is on air is held. Its pair starts on the clock edge after the current pair's last pulse ends, ahead of any filler.
- R5: A filler pair starts only when all of these hold: the sequencer is idle, no reply is held or requested, the filler timer has expired, and the count over the completed window is below `cfg_min_pairs`. `tx_filler` is high from the start of a filler pair until the next reply pair starts.
- R6: At every pair start the filler timer loads min(`cfg_fill_base` + (LFSR & `cfg_fill_mask`), `cfg_fill_cap`). An unblocked filler then starts that many cycles plus one after the previous pair start. Successive gaps vary.
- R7: With no replies, a filler cap below half a sub-interval and an achievable minimum, every window-length span holds at least `cfg_min_pairs` − 3 pairs and at most `cfg_min_pairs` + 6 pairs.
- R8: At each window boundary, if the completed-window count exceeds `cfg_max_pairs` and `thr_offset` is below `cfg_ofs_max`, the offset rises by one. It changes by at most one step per window and never exceeds `cfg_ofs_max`.
- R9: At a window boundary the offset falls by one when ten times the count is below nine times `cfg_max_pairs`. Between 90% and 100% of the maximum it holds.
- R10: `overload` is high exactly when `thr_offset` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reply_req | input | 1 | One-cycle strobe from the decoder requesting a reply pair |
| cfg_wide_space | input | 1 | 0 selects narrow pair spacing, 1 selects wide |
| cfg_min_pairs | input | CNT_W | Minimum pairs per window |
| cfg_max_pairs | input | CNT_W | Maximum pairs per window |
| cfg_ofs_max | input | OFS_W | Ceiling for the threshold offset in 1 dB steps |
| cfg_fill_base | input | TMR_W | Base filler gap in clocks |
| cfg_fill_mask | input | TMR_W | Mask applied to the LFSR before it is added to the base |
| cfg_fill_cap | input | TMR_W | Upper bound on the filler gap |
| tx_gate | output | 1 | Gate pulses of the current pair |
| tx_filler | output | 1 | High while the latest pair is a filler |
| thr_offset | output | OFS_W | Sensitivity reduction toward the receiver threshold, in dB |
| overload | output | 1 | High while sensitivity is reduced by traffic |

## Verification
The bench issues a reply request while a pair is still on air. A design without the one-deep hold would lose that reply, and one with the wrong priority would start a filler first. Either way the scoreboard sees a missing or out-of-order reply pair. Filler gaps are timed against the base/mask/cap bounds, including a cap tighter than base plus mask. They are also compared across many fillers, so a fixed interval or an unbounded sum shows up. The rate loop is pushed above the ceiling until the offset reaches its cap. It is then held at 19 of a 20 maximum, where a design with a wrong 90% threshold would step down. Last, traffic is stopped, and the offset must fall back one step per window.

// File: rtl/rrg_pkg.sv
package rrg_pkg;

  typedef enum logic [1:0] {
    PG_IDLE,
    PG_FIRST,
    PG_GAP,
    PG_SECOND
  } pg_state_e;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

endpackage

// File: rtl/rrg_lfsr.sv
module rrg_lfsr
  import rrg_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  output logic [LFSR_W-1:0] value
);

  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED;
    end else begin
      state_q <= {1'b0, state_q[LFSR_W-1:1]} ^ (state_q[0] ? LFSR_TAPS : '0);
    end
  end

  assign value = state_q;

endmodule

// File: rtl/rrg_pair_gen.sv
module rrg_pair_gen
  import rrg_pkg::*;
#(
  parameter int unsigned GATE_W  = 175,
  parameter int unsigned SPACE_N = 600,
  parameter int unsigned SPACE_W = 1800
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic wide,
  output logic gate,
  output logic busy
);

  localparam int unsigned CW = $clog2(SPACE_W + GATE_W + 1);
  localparam logic [CW-1:0] GATE_LAST = CW'(GATE_W - 1);
  localparam logic [CW-1:0] SPC_N = CW'(SPACE_N);
  localparam logic [CW-1:0] SPC_W = CW'(SPACE_W);

  pg_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] space_q;
  logic          gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PG_IDLE;
      cnt_q   <= '0;
      space_q <= SPC_N;
      gate_q  <= 1'b0;
    end else begin
      unique case (state_q)
        PG_IDLE: begin
          if (start) begin
            state_q <= PG_FIRST;
            cnt_q   <= '0;
            space_q <= wide ? SPC_W : SPC_N;
            gate_q  <= 1'b1;
          end
        end
        PG_FIRST: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == GATE_LAST) begin
            gate_q  <= 1'b0;
            state_q <= PG_GAP;
          end
        end
        PG_GAP: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == space_q - 1'b1) begin
            gate_q  <= 1'b1;
            cnt_q   <= '0;
            state_q <= PG_SECOND;
          end
        end
        PG_SECOND: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == GATE_LAST) begin
            gate_q  <= 1'b0;
            state_q <= PG_IDLE;
          end
        end
        default: state_q <= PG_IDLE;
      endcase
    end
  end

  assign gate = gate_q;
  assign busy = (state_q != PG_IDLE);

endmodule

// File: rtl/rrg_rate_window.sv
module rrg_rate_window #(
  parameter int unsigned SUB_CLKS = 3125000,
  parameter int unsigned NSUB     = 16,
  parameter int unsigned CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pair_start,
  output logic [CNT_W-1:0] win_sum,
  output logic             win_tick
);

  localparam int unsigned SC_W  = $clog2(SUB_CLKS);
  localparam int unsigned IDX_W = (NSUB > 1) ? $clog2(NSUB) : 1;
  localparam logic [SC_W-1:0]  SUB_LAST = SC_W'(SUB_CLKS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NSUB - 1);

  logic [SC_W-1:0]  sub_cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cur_q;
  logic [CNT_W-1:0] sum_q;
  logic             tick_q;
  logic [CNT_W-1:0] slot [NSUB];

  logic             sub_last;
  logic [CNT_W-1:0] cur_total;

  assign sub_last  = (sub_cnt_q == SUB_LAST);
  assign cur_total = cur_q + CNT_W'(pair_start);

  // One register per sub-interval slot, written when its turn comes round.
  for (genvar g = 0; g < NSUB; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot[g] <= '0;
      end else if (sub_last && idx_q == IDX_W'(g)) begin
        slot[g] <= cur_total;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_cnt_q <= '0;
      idx_q     <= '0;
      cur_q     <= '0;
      sum_q     <= '0;
      tick_q    <= 1'b0;
    end else if (sub_last) begin
      sub_cnt_q <= '0;
      cur_q     <= '0;
      sum_q     <= sum_q + cur_total - slot[idx_q];
      idx_q     <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
      tick_q    <= (idx_q == IDX_LAST);
    end else begin
      sub_cnt_q <= sub_cnt_q + 1'b1;
      cur_q     <= cur_total;
      tick_q    <= 1'b0;
    end
  end

  assign win_sum  = sum_q;
  assign win_tick = tick_q;

endmodule

// File: rtl/rrg_threshold_ctl.sv
module rrg_threshold_ctl #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned OFS_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_tick,
  input  logic [CNT_W-1:0] win_sum,
  input  logic [CNT_W-1:0] cfg_max_pairs,
  input  logic [OFS_W-1:0] cfg_ofs_max,
  output logic [OFS_W-1:0] thr_offset,
  output logic             overload
);

  localparam int unsigned PROD_W = CNT_W + 4;

  logic [OFS_W-1:0]  ofs_q;
  logic [OFS_W-1:0]  ofs_d;
  logic              ovl_q;
  logic              too_high;
  logic              well_low;
  logic [PROD_W-1:0] sum_x10;
  logic [PROD_W-1:0] max_x9;

  assign sum_x10  = PROD_W'(win_sum) * PROD_W'(10);
  assign max_x9   = PROD_W'(cfg_max_pairs) * PROD_W'(9);
  assign too_high = (win_sum > cfg_max_pairs);
  assign well_low = (sum_x10 < max_x9);

  always_comb begin
    ofs_d = ofs_q;
    if (win_tick) begin
      if (too_high && ofs_q < cfg_ofs_max) begin
        ofs_d = ofs_q + 1'b1;
      end else if (well_low && ofs_q != '0) begin
        ofs_d = ofs_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q <= '0;
      ovl_q <= 1'b0;
    end else begin
      ofs_q <= ofs_d;
      ovl_q <= (ofs_d != '0);
    end
  end

  assign thr_offset = ofs_q;
  assign overload   = ovl_q;

endmodule

// File: rtl/rrg_governor.sv
module rrg_governor
  import rrg_pkg::*;
#(
  parameter int unsigned SUB_CLKS = 3125000,
  parameter int unsigned NSUB     = 16,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned OFS_W    = 5,
  parameter int unsigned TMR_W    = 24,
  parameter int unsigned GATE_W   = 175,
  parameter int unsigned SPACE_N  = 600,
  parameter int unsigned SPACE_W  = 1800,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reply_req,
  input  logic             cfg_wide_space,
  input  logic [CNT_W-1:0] cfg_min_pairs,
  input  logic [CNT_W-1:0] cfg_max_pairs,
  input  logic [OFS_W-1:0] cfg_ofs_max,
  input  logic [TMR_W-1:0] cfg_fill_base,
  input  logic [TMR_W-1:0] cfg_fill_mask,
  input  logic [TMR_W-1:0] cfg_fill_cap,
  output logic             tx_gate,
  output logic             tx_filler,
  output logic [OFS_W-1:0] thr_offset,
  output logic             overload
);

  logic [LFSR_W-1:0] lfsr_val;
  logic [CNT_W-1:0]  win_sum;
  logic              win_tick;
  logic              pg_busy;
  logic              pend_q;
  logic              fill_q;
  logic [TMR_W-1:0]  tmr_q;
  logic [TMR_W:0]    gap_raw;
  logic [TMR_W-1:0]  gap_next;
  logic              start_reply;
  logic              start_fill;
  logic              pair_start;

  rrg_lfsr #(.SEED(SEED)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .value (lfsr_val)
  );

  rrg_pair_gen #(
    .GATE_W  (GATE_W),
    .SPACE_N (SPACE_N),
    .SPACE_W (SPACE_W)
  ) u_pair (
    .clk   (clk),
    .rst   (rst),
    .start (pair_start),
    .wide  (cfg_wide_space),
    .gate  (tx_gate),
    .busy  (pg_busy)
  );

  rrg_rate_window #(
    .SUB_CLKS (SUB_CLKS),
    .NSUB     (NSUB),
    .CNT_W    (CNT_W)
  ) u_win (
    .clk        (clk),
    .rst        (rst),
    .pair_start (pair_start),
    .win_sum    (win_sum),
    .win_tick   (win_tick)
  );

  rrg_threshold_ctl #(
    .CNT_W (CNT_W),
    .OFS_W (OFS_W)
  ) u_thr (
    .clk           (clk),
    .rst           (rst),
    .win_tick      (win_tick),
    .win_sum       (win_sum),
    .cfg_max_pairs (cfg_max_pairs),
    .cfg_ofs_max   (cfg_ofs_max),
    .thr_offset    (thr_offset),
    .overload      (overload)
  );

  // Replies always win the idle sequencer; a filler needs a clear field.
  assign start_reply = !pg_busy && (pend_q || reply_req);
  assign start_fill  = !pg_busy && !pend_q && !reply_req && (tmr_q == '0) &&
                       (win_sum < cfg_min_pairs);
  assign pair_start  = start_reply || start_fill;

  // Random gap, bounded by the cap so the minimum rate stays reachable.
  assign gap_raw  = {1'b0, cfg_fill_base} + {1'b0, cfg_fill_mask & TMR_W'(lfsr_val)};
  assign gap_next = (gap_raw > {1'b0, cfg_fill_cap}) ? cfg_fill_cap : gap_raw[TMR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      fill_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      if (start_reply) begin
        pend_q <= pend_q && reply_req;
      end else begin
        pend_q <= pend_q || reply_req;
      end

      if (start_fill) begin
        fill_q <= 1'b1;
      end else if (start_reply) begin
        fill_q <= 1'b0;
      end

      if (pair_start) begin
        tmr_q <= gap_next;
      end else if (tmr_q != '0) begin
        tmr_q <= tmr_q - 1'b1;
      end
    end
  end

  assign tx_filler = fill_q;

endmodule

// File: rtl/rrg_governor_chk.sv
module rrg_governor_chk #(
  parameter int unsigned GATE_W   = 175,
  parameter int unsigned WIN_CLKS = 50000000,
  parameter int unsigned OFS_W    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_gate,
  input logic             tx_filler,
  input logic [OFS_W-1:0] thr_offset,
  input logic [OFS_W-1:0] cfg_ofs_max,
  input logic             pend_q,
  input logic             pg_busy
);

  logic [31:0]      hi_cnt_q;
  logic [31:0]      gap_q;
  logic [OFS_W-1:0] prev_ofs_q;
  logic             ofs_chg;

  assign ofs_chg = (thr_offset != prev_ofs_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt_q   <= '0;
      gap_q      <= '0;
      prev_ofs_q <= '0;
    end else begin
      hi_cnt_q   <= tx_gate ? hi_cnt_q + 1 : '0;
      prev_ofs_q <= thr_offset;
      if (ofs_chg) begin
        gap_q <= '0;
      end else if (gap_q < WIN_CLKS) begin
        gap_q <= gap_q + 1;
      end
    end
  end

  // R2: pulse width
  p_gate_width_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_gate) |-> (hi_cnt_q == GATE_W));

  // R4: a held reply starts next, and it is not a filler
  p_reply_first_r4: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !pg_busy) |=> (tx_gate && !tx_filler));

  // R8: ceiling on the offset
  p_ofs_cap_r8: assert property (@(posedge clk) disable iff (rst)
    thr_offset <= cfg_ofs_max);

  // R8: single-step moves only
  p_ofs_step_r8: assert property (@(posedge clk) disable iff (rst)
    (thr_offset != $past(thr_offset)) |->
      (({1'b0, thr_offset} == {1'b0, $past(thr_offset)} + 1'b1) ||
       ({1'b0, thr_offset} + 1'b1 == {1'b0, $past(thr_offset)})));

  // R8: no two steps inside one window
  p_once_per_window_r8: assert property (@(posedge clk) disable iff (rst)
    ofs_chg |-> (gap_q >= WIN_CLKS / 2));

endmodule

bind rrg_governor rrg_governor_chk #(
  .GATE_W   (GATE_W),
  .WIN_CLKS (SUB_CLKS * NSUB),
  .OFS_W    (OFS_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_gate     (tx_gate),
  .tx_filler   (tx_filler),
  .thr_offset  (thr_offset),
  .cfg_ofs_max (cfg_ofs_max),
  .pend_q      (pend_q),
  .pg_busy     (pg_busy)
);

// File: tb/rrg_governor_tb.sv
module rrg_governor_tb;

  localparam int SUB   = 100;
  localparam int NS    = 16;
  localparam int WIN   = SUB * NS;
  localparam int CW    = 12;
  localparam int OW    = 4;
  localparam int TW    = 16;
  localparam int GW    = 4;
  localparam int SN    = 12;
  localparam int SW    = 36;

  typedef struct {
    int sp;
    bit tight;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reply_req = 1'b0;
  logic          cfg_wide_space = 1'b0;
  logic [CW-1:0] cfg_min_pairs = '0;
  logic [CW-1:0] cfg_max_pairs = 12'd4000;
  logic [OW-1:0] cfg_ofs_max = 4'd3;
  logic [TW-1:0] cfg_fill_base = 16'd30;
  logic [TW-1:0] cfg_fill_mask = 16'h001F;
  logic [TW-1:0] cfg_fill_cap = 16'd50;
  logic          tx_gate;
  logic          tx_filler;
  logic [OW-1:0] thr_offset;
  logic          overload;

  always #5 clk = ~clk;

  rrg_governor #(
    .SUB_CLKS (SUB), .NSUB (NS), .CNT_W (CW), .OFS_W (OW), .TMR_W (TW),
    .GATE_W (GW), .SPACE_N (SN), .SPACE_W (SW)
  ) u_dut (
    .clk (clk), .rst (rst), .reply_req (reply_req),
    .cfg_wide_space (cfg_wide_space), .cfg_min_pairs (cfg_min_pairs),
    .cfg_max_pairs (cfg_max_pairs), .cfg_ofs_max (cfg_ofs_max),
    .cfg_fill_base (cfg_fill_base), .cfg_fill_mask (cfg_fill_mask),
    .cfg_fill_cap (cfg_fill_cap), .tx_gate (tx_gate), .tx_filler (tx_filler),
    .thr_offset (thr_offset), .overload (overload)
  );

  exp_t sb_q[$];
  int   checks = 0, errs = 0;
  int   mon_checks = 0, mon_errs = 0;
  int   replies_sent = 0;
  int   epoch = 0;
  bit   fill_chk_en = 1'b0;

  // monitor state
  int cyc = 0, ph = 0, r1 = 0, f1 = 0, r2 = 0, f2 = 0;
  int last_start = 0, last_end = 0, seen_epoch = 0;
  int pair_total = 0, filler_total = 0, reply_pairs = 0;
  int gap_min = 1000000, gap_max = 0;
  bit have_prev = 1'b0, prev_g = 1'b0, fl = 1'b0;
  int exp_sp;

  task automatic mon_chk(input bit ok, input string tag, input int act, input int exp);
    mon_checks++;
    if (!ok) begin
      mon_errs++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: rebuilds each pair at the negative edge and scores it.
  always @(negedge clk) begin
    cyc++;
    if (rst) begin
      ph = 0;
      prev_g = 1'b0;
    end else begin
      if (tx_gate && !prev_g) begin
        if (ph == 0) begin
          r1 = cyc; fl = tx_filler; ph = 1;
          exp_sp = cfg_wide_space ? SW : SN;
        end else if (ph == 2) begin
          r2 = cyc; ph = 3;
        end
      end else if (!tx_gate && prev_g) begin
        if (ph == 1) begin
          f1 = cyc; ph = 2;
        end else if (ph == 3) begin
          f2 = cyc; ph = 0;
          mon_chk(f1 - r1 == GW, "R2 first pulse width", f1 - r1, GW);
          mon_chk(f2 - r2 == GW, "R2 second pulse width", f2 - r2, GW);
          if (fl) begin
            filler_total++;
            mon_chk(r2 - r1 == exp_sp, "R3 filler spacing", r2 - r1, exp_sp);
            if (fill_chk_en && have_prev && seen_epoch == epoch) begin
              mon_chk((r1 - last_start >= int'(cfg_fill_base) + 1) &&
                      (r1 - last_start <= int'(cfg_fill_cap) + 1),
                      "R6 filler gap", r1 - last_start, int'(cfg_fill_cap) + 1);
              if (r1 - last_start < gap_min) gap_min = r1 - last_start;
              if (r1 - last_start > gap_max) gap_max = r1 - last_start;
            end
          end else begin
            reply_pairs++;
            if (sb_q.size() == 0) begin
              mon_chk(1'b0, "R4 unexpected reply pair", reply_pairs, 0);
            end else begin
              exp_t it;
              it = sb_q.pop_front();
              mon_chk(r2 - r1 == it.sp, "R3 reply spacing", r2 - r1, it.sp);
              if (it.tight)
                mon_chk(r1 - last_end <= 2, "R4 held reply start", r1 - last_end, 2);
            end
          end
          have_prev = 1'b1;
          seen_epoch = epoch;
          last_start = r1;
          last_end = f2;
          pair_total++;
        end
      end
      prev_g = tx_gate;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: pushes the expected pair, then pulses the request for one cycle.
  task automatic send_reply(input int sp, input bit tight);
    exp_t it;
    it.sp = sp;
    it.tight = tight;
    sb_q.push_back(it);
    replies_sent++;
    reply_req = 1'b1;
    @(negedge clk);
    reply_req = 1'b0;
  endtask

  task automatic finish_run(input int extra);
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks + extra,
             errs + mon_errs + extra);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog actual %0d expected %0d", 190000, 0);
    finish_run(1);
  end

  initial begin
    int f0, c0, prev_ofs;
    wait_cyc(3);
    // R1: reset state
    chk(tx_gate == 1'b0, "R1 gate in reset", tx_gate, 0);
    chk(tx_filler == 1'b0, "R1 filler in reset", tx_filler, 0);
    chk(thr_offset == '0, "R1 offset in reset", thr_offset, 0);
    chk(overload == 1'b0, "R1 overload in reset", overload, 0);
    rst = 1'b0;
    wait_cyc(5);

    // R3: narrow, wide, and spacing latched at pair start
    send_reply(SN, 1'b0); wait_cyc(40);
    cfg_wide_space = 1'b1; wait_cyc(1);
    send_reply(SW, 1'b0); wait_cyc(60);
    send_reply(SW, 1'b0); wait_cyc(2);
    cfg_wide_space = 1'b0; wait_cyc(60);

    // R4: request while a pair is on air is held and follows at once
    send_reply(SN, 1'b0); wait_cyc(3);
    send_reply(SN, 1'b1); wait_cyc(60);
    chk(sb_q.size() == 0, "R4 held reply emitted", sb_q.size(), 0);
    // R5: no filler with a zero minimum
    chk(filler_total == 0, "R5 no filler below zero minimum", filler_total, 0);

    // R5/R6: continuous fillers with random bounded gaps
    epoch++; fill_chk_en = 1'b1;
    cfg_min_pairs = 12'd1000;
    wait_cyc(3000);
    chk(filler_total > 40, "R5 fillers issued under minimum", filler_total, 41);
    chk(gap_max > gap_min, "R6 filler gaps vary", gap_max, gap_min + 1);

    // R5: replies interleaved with fillers keep priority and all appear
    for (int i = 0; i < 10; i++) begin
      send_reply(SN, 1'b0);
      wait_cyc(136);
    end
    wait_cyc(100);
    chk(sb_q.size() == 0, "R5 replies not lost among fillers", sb_q.size(), 0);

    // R6: cap tighter than base plus mask
    epoch++;
    cfg_fill_base = 16'd40; cfg_fill_mask = 16'h00FF; cfg_fill_cap = 16'd45;
    wait_cyc(2000);

    // R7: fillers alone settle near the minimum per window
    fill_chk_en = 1'b0;
    epoch++;
    cfg_min_pairs = 12'd20;
    cfg_fill_base = 16'd30; cfg_fill_mask = 16'h001F; cfg_fill_cap = 16'd50;
    wait_cyc(4 * WIN);
    for (int w = 0; w < 3; w++) begin
      c0 = pair_total;
      wait_cyc(WIN);
      chk((pair_total - c0 >= 17) && (pair_total - c0 <= 26),
          "R7 pairs per window", pair_total - c0, 20);
    end

    // R8: heavy traffic raises the offset one step per window up to the cap
    cfg_min_pairs = '0;
    cfg_max_pairs = 12'd10;
    f0 = filler_total;
    prev_ofs = thr_offset;
    for (int w = 0; w < 7; w++) begin
      for (int k = 0; k < 40; k++) begin
        send_reply(SN, 1'b0);
        wait_cyc(39);
      end
      chk(int'(thr_offset) - prev_ofs <= 1 && int'(thr_offset) >= prev_ofs,
          "R8 single rise per window", thr_offset, prev_ofs + 1);
      chk(overload == (thr_offset != '0), "R10 overload tracks offset", overload, thr_offset != '0);
      prev_ofs = thr_offset;
    end
    chk(thr_offset == 4'd3, "R8 offset at cap", thr_offset, 3);
    chk(overload == 1'b1, "R10 overload raised", overload, 1);
    chk(filler_total == f0, "R5 no filler with zero minimum", filler_total, f0);

    // R9: 19 pairs per window against a maximum of 20 holds the offset
    cfg_max_pairs = 12'd20;
    for (int w = 0; w < 5; w++) begin
      for (int k = 0; k < 19; k++) begin
        send_reply(SN, 1'b0);
        wait_cyc(83);
      end
      if (w >= 2) chk(thr_offset == 4'd3, "R9 hold inside band", thr_offset, 3);
    end

    // R9: traffic stops, offset walks back to zero one step per window
    prev_ofs = thr_offset;
    for (int w = 0; w < 6; w++) begin
      wait_cyc(WIN);
      chk(prev_ofs - int'(thr_offset) <= 1 && int'(thr_offset) <= prev_ofs,
          "R9 single fall per window", thr_offset, prev_ofs - 1);
      chk(overload == (thr_offset != '0), "R10 overload tracks offset", overload, thr_offset != '0);
      prev_ofs = thr_offset;
    end
    chk(thr_offset == '0, "R9 offset back to zero", thr_offset, 0);
    chk(overload == 1'b0, "R10 overload cleared", overload, 0);

    wait_cyc(100);
    chk(sb_q.size() == 0, "R4 scoreboard drained", sb_q.size(), 0);
    chk(reply_pairs == replies_sent, "R4 one pair per request", reply_pairs, replies_sent);
    finish_run(0);
  end

endmodule